// File: doc/BRIEF.md
# Carry-Select Adder

This block adds two unsigned (or two's-complement) operands of a parameterised even width and returns the sum and the carry out of the top bit. It avoids sending one carry through the full width. The operand bits split into a lower half and an upper half. The lower half is summed with no carry in. The upper half is summed twice at the same time, once assuming no carry arrives and once assuming one does. The lower half's carry out then picks one of the two upper results.

A parameter can apply the same split once more inside each half-width adder. The design then works in quarters, which costs more full adders and shortens the longest carry path. The combined result is captured in an output register, so it appears one clock after the operands are applied. The register has an asynchronous active-low reset.

Top module: `csa_adder`

## Requirements
- R1: While `rst_n` is low, `sum_o` and `cout_o` read zero.
- R2: The value `{cout_o, sum_o}` seen after a rising clock edge equals the full-precision sum `a_i + b_i` of the operands present at that edge, so the latency is one cycle.
- R3: If the lower halves of the operands overflow, the upper half of the sum equals the sum of the operands' upper halves plus one. For a 32-bit width, 0x0000FFFF + 0x00000001 gives 0x00010000.
- R4: The carry out comes from the same upper-half computation whose sum was chosen. For example, 0xFFFF0000 + 0x00000000 gives carry 0, and 0xFFFF0000 + 0x00010000 gives sum 0 and carry 1.
- R5: A carry produced at bit 0 travels through every bit. 0x7FFFFFFF + 1 gives 0x80000000 with carry 0, and 0xFFFFFFFF + 1 gives 0x00000000 with carry 1.
- R6: The lower half sees no carry in. 0 + 0 gives 0 with carry 0.
- R7: Setting `SPLIT` = 1 splits each half-width adder again into quarters with the same selection scheme, and every result stays identical to the `SPLIT` = 0 build.
- R8: Arbitrary operand pairs produce the mathematically correct sum and carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| sum_o | output | W | Registered sum, low W bits |
| cout_o | output | 1 | Registered carry out of bit W-1 |

## Verification
The bench aims at the operands that stress the selection point. One case is a lower half that just overflows. A design that ignored the lower carry would return the upper half one short. Another case is an upper half of all ones, where the two upper candidates disagree on carry. A design that took the carry from the wrong candidate would report a phantom carry or lose a real one. The bench also runs full-width carry chains and random pairs on both the single-split and the quarter-split builds. A wrong carry in on the lower half would show up as an off-by-one on 0 + 0.

// File: rtl/csa_pkg.sv
package csa_pkg;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  import csa_pkg::*;

  logic [W:0] chain;
  assign chain[0] = c_i;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign s_o[k]       = fa_sum(x_i[k], y_i[k], chain[k]);
    assign chain[k + 1] = fa_carry(x_i[k], y_i[k], chain[k]);
  end

  assign c_o = chain[W];
endmodule

// File: rtl/csa_unit.sv
module csa_unit #(
  parameter int W     = 16,
  parameter int SPLIT = 0
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  if (SPLIT == 0) begin : g_flat
    csa_ripple #(.W(W)) rip_i (
      .x_i(x_i), .y_i(y_i), .c_i(c_i), .s_o(s_o), .c_o(c_o)
    );
  end else begin : g_split
    localparam int LW = W / 2;
    localparam int HW = W - LW;

    logic [LW-1:0] lo_s;
    logic          lo_c;
    logic [HW-1:0] h0_s, h1_s;
    logic          h0_c, h1_c;

    csa_ripple #(.W(LW)) lo_i (
      .x_i(x_i[LW-1:0]), .y_i(y_i[LW-1:0]), .c_i(c_i), .s_o(lo_s), .c_o(lo_c)
    );
    csa_ripple #(.W(HW)) h0_i (
      .x_i(x_i[W-1:LW]), .y_i(y_i[W-1:LW]), .c_i(1'b0), .s_o(h0_s), .c_o(h0_c)
    );
    csa_ripple #(.W(HW)) h1_i (
      .x_i(x_i[W-1:LW]), .y_i(y_i[W-1:LW]), .c_i(1'b1), .s_o(h1_s), .c_o(h1_c)
    );

    always_comb begin
      if (lo_c) begin
        s_o = {h1_s, lo_s};
        c_o = h1_c;
      end else begin
        s_o = {h0_s, lo_s};
        c_o = h0_c;
      end
    end
  end
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int W     = 32,
  parameter int SPLIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int LW = W / 2;
  localparam int HW = W - LW;

  logic [LW-1:0] lo_s;
  logic          lo_c;
  logic [HW-1:0] h0_s, h1_s;
  logic          h0_c, h1_c;
  logic [W-1:0]  sum_d, sum_q;
  logic          cout_d, cout_q;

  // lower half: carry in tied low
  csa_unit #(.W(LW), .SPLIT(SPLIT)) lo_i (
    .x_i(a_i[LW-1:0]), .y_i(b_i[LW-1:0]), .c_i(1'b0), .s_o(lo_s), .c_o(lo_c)
  );
  // upper half, both carry assumptions in parallel
  csa_unit #(.W(HW), .SPLIT(SPLIT)) h0_i (
    .x_i(a_i[W-1:LW]), .y_i(b_i[W-1:LW]), .c_i(1'b0), .s_o(h0_s), .c_o(h0_c)
  );
  csa_unit #(.W(HW), .SPLIT(SPLIT)) h1_i (
    .x_i(a_i[W-1:LW]), .y_i(b_i[W-1:LW]), .c_i(1'b1), .s_o(h1_s), .c_o(h1_c)
  );

  // next-state: select upper candidate by lower carry
  always_comb begin
    if (lo_c) begin
      sum_d  = {h1_s, lo_s};
      cout_d = h1_c;
    end else begin
      sum_d  = {h0_s, lo_s};
      cout_d = h0_c;
    end
  end

  // result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end

  assign sum_o  = sum_q;
  assign cout_o = cout_q;

  // R1: outputs cleared under reset
  p_rst_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (sum_o == '0 && cout_o == 1'b0));

  // R2: registered result is the full sum of last cycle's operands
  p_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ({cout_o, sum_o} == ($past({1'b0, a_i}) + $past({1'b0, b_i}))));

  // R3: carry-in-one candidate is exactly one above the carry-in-zero candidate
  p_cand_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    {h1_c, h1_s} == ({h0_c, h0_s} + {{HW{1'b0}}, 1'b1}));

  // R4: an upper carry with no incoming carry implies a carry with one
  p_carry_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    h0_c |-> h1_c);

  // R6: lower half equals the plain lower-operand sum, no carry in
  p_low_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    {lo_c, lo_s} == ({1'b0, a_i[LW-1:0]} + {1'b0, b_i[LW-1:0]}));
endmodule

// File: tb/csa_adder_tb.sv
module csa_adder_tb_top;
  localparam int  W       = 32;
  localparam time CLK_PER = 10ns;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a, b;
  logic [W-1:0] s_flat, s_quad;
  logic         c_flat, c_quad;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [W:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  csa_adder #(.W(W), .SPLIT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .sum_o(s_flat), .cout_o(c_flat)
  );
  csa_adder #(.W(W), .SPLIT(1)) dut_q_i (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .sum_o(s_quad), .cout_o(c_quad)
  );

  initial clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply operands at falling edge, push expectation
  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    item_t it;
    @(negedge clk);
    a = x;
    b = y;
    it.exp = {1'b0, x} + {1'b0, y};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: one result per rising edge, sampled after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check({it.tag, " split0"}, {c_flat, s_flat}, it.exp);
        check({"R7 ", it.tag, " split1"}, {c_quad, s_quad}, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs zero in reset
    check("R1 reset split0", {c_flat, s_flat}, '0);
    check("R1 reset split1", {c_quad, s_quad}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    drive(32'h0000_0000, 32'h0000_0000, "R6 zero");
    drive(32'h0000_0001, 32'h0000_0000, "R6 one");
    drive(32'h0000_FFFF, 32'h0000_0001, "R3 low overflow");
    drive(32'h1234_8000, 32'h0001_8000, "R3 low overflow upper add");
    drive(32'hFFFF_0000, 32'h0000_0000, "R4 upper ones no carry");
    drive(32'hFFFF_0000, 32'h0001_0000, "R4 upper carry");
    drive(32'hFFFF_8000, 32'h0000_8000, "R4 selected carry");
    drive(32'h7FFF_FFFF, 32'h0000_0001, "R5 chain to msb");
    drive(32'hFFFF_FFFF, 32'h0000_0001, "R5 full wrap");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 max plus max");
    drive(32'h00FF_00FF, 32'h0000_FF01, "R2 quarter carry");
    for (int n = 0; n < 200; n++) begin
      drive($urandom(), $urandom(), "R8 random");
    end
    repeat (4) @(posedge clk);
    #1;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R2 pending actual=%0d expected=0", sb_q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule